// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns the operand fields of a load, store or memory-operand ALU instruction into the address of the operand. A request carries a mode code, the base and index register values, a 16-bit signed displacement, a scale selector, the program counter, a branch offset and an absolute address. In the cycle after the request, the unit presents the effective address with a one-cycle done strobe. For the two auto-modify modes it also presents a new base value with a write enable, which the register file applies.

The memory-indirect mode needs a pointer from memory, so it takes two steps. The unit issues a one-cycle read on its memory port, using the base value as the address. It then waits, with done held low, until the read returns. The returned word becomes the effective address. While this read is pending the unit ignores any new request. All other modes take a single cycle.

All address arithmetic is 32 bits wide and wraps modulo 2^32. The element size used by the scaled, autoincrement and autodecrement modes is 1, 2, 4 or 8 bytes, for scale selector values 0, 1, 2 and 3.

Top module: `eag_top`

## Requirements
- R1: After synchronous reset, done, wb_en and mem_rd_en are low until a request is accepted.
- R2: Mode code 0 (register indirect) gives ea = base_val. The unused codes 9 to 15 behave in the same way.
- R3: Mode code 8 (direct) gives ea = abs_addr.
- R4: Mode code 4 (displacement) gives ea = base_val + disp, where disp is sign-extended from 16 bits.
- R5: Mode code 5 (indexed) gives ea = base_val + index_val.
- R6: Mode code 6 (scaled) gives ea = sext(disp) + base_val + index_val * 2^scale_sel, with scale_sel in 0..3. For example, disp 0, base 400, index 3 and scale_sel 2 give 412.
- R7: Mode code 7 (PC-relative) gives ea = pc_val + br_off.
- R8: Mode code 2 (autoincrement) gives ea = base_val, wb_en high and wb_val = base_val + 2^scale_sel.
- R9: Mode code 3 (autodecrement) gives ea = wb_val = base_val - 2^scale_sel, with wb_en high.
- R10: For every mode except code 1, an accepted request gives done high for exactly the next cycle. wb_en is high only with done, and only for codes 2 and 3.
- R11: Mode code 1 (memory indirect) gives a one-cycle mem_rd_en pulse in the next cycle, with mem_rd_addr = base_val and done low. done stays low until the cycle after mem_rd_valid is seen. In that cycle ea equals mem_rd_data and wb_en is low.
- R12: A request that arrives while a pointer read is pending is ignored. A mem_rd_valid that arrives while no read is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request strobe |
| mode | input | 4 | Addressing mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| disp | input | 16 | Signed displacement |
| scale_sel | input | 2 | Log2 of the element size |
| pc_val | input | 32 | Program counter |
| br_off | input | 32 | Signed branch offset |
| abs_addr | input | 32 | Absolute address from the instruction |
| mem_rd_en | output | 1 | Pointer read request |
| mem_rd_addr | output | 32 | Pointer read address |
| mem_rd_valid | input | 1 | Pointer read data valid |
| mem_rd_data | input | 32 | Pointer read data |
| done | output | 1 | Effective address valid |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base register write enable |
| wb_val | output | 32 | New base register value |

## Verification
The bench targets the following corner cases.

- Negative displacements and negative branch offsets. If the sign extension were dropped, the address would land 64 KiB too high.
- Every scale selector. A wrong shift would scale the index, or step the base, by the wrong element size.
- Autodecrement from base zero. It must wrap to the top of the address space. A design that used the old base would present an address one element too high.
- Memory-indirect reads with zero and with several wait cycles. A design that asserted done early would present the pointer's address instead of the pointer.
- A request during a pending read, and a stray read response while idle. A design that honoured either would emit a spurious done.

// File: rtl/eag_pkg.sv
package eag_pkg;

    parameter int unsigned EAG_AW = 32;
    parameter int unsigned EAG_DW = 16;
    parameter int unsigned EAG_MW = 4;
    parameter int unsigned EAG_SW = 2;
    localparam int unsigned EAG_NSCALE = 1 << EAG_SW;

    typedef enum logic [EAG_MW-1:0] {
        AM_REG_IND  = 4'd0,
        AM_MEM_IND  = 4'd1,
        AM_AUTO_INC = 4'd2,
        AM_AUTO_DEC = 4'd3,
        AM_DISP     = 4'd4,
        AM_INDEXED  = 4'd5,
        AM_SCALED   = 4'd6,
        AM_PC_REL   = 4'd7,
        AM_DIRECT   = 4'd8
    } addr_mode_e;

    typedef struct packed {
        logic [EAG_AW-1:0] addr;
        logic              wb_en;
        logic [EAG_AW-1:0] wb_val;
        logic              indirect;
    } calc_res_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    function automatic logic [EAG_AW-1:0] sext_disp(input logic [EAG_DW-1:0] d);
        return {{(EAG_AW-EAG_DW){d[EAG_DW-1]}}, d};
    endfunction

endpackage

// File: rtl/eag_index_scale.sv
module eag_index_scale
    import eag_pkg::*;
(
    input  logic [EAG_AW-1:0] index_in,
    input  logic [EAG_SW-1:0] sel,
    output logic [EAG_AW-1:0] scaled,
    output logic [EAG_AW-1:0] elem_bytes
);
    logic [EAG_AW-1:0] shifted [EAG_NSCALE];
    logic [EAG_AW-1:0] sizes   [EAG_NSCALE];

    for (genvar g = 0; g < EAG_NSCALE; g++) begin : g_shift
        assign shifted[g] = index_in << g;
        assign sizes[g]   = EAG_AW'(1) << g;
    end

    assign scaled     = shifted[sel];
    assign elem_bytes = sizes[sel];
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
(
    input  logic [EAG_MW-1:0] mode,
    input  logic [EAG_AW-1:0] base_val,
    input  logic [EAG_AW-1:0] index_val,
    input  logic [EAG_DW-1:0] disp,
    input  logic [EAG_SW-1:0] scale_sel,
    input  logic [EAG_AW-1:0] pc_val,
    input  logic [EAG_AW-1:0] br_off,
    input  logic [EAG_AW-1:0] abs_addr,
    output calc_res_t         res
);
    logic [EAG_AW-1:0] idx_scaled;
    logic [EAG_AW-1:0] elem;
    logic [EAG_AW-1:0] disp_ext;

    eag_index_scale u_scale (
        .index_in  (index_val),
        .sel       (scale_sel),
        .scaled    (idx_scaled),
        .elem_bytes(elem)
    );

    assign disp_ext = sext_disp(disp);

    always_comb begin
        res.addr     = base_val;
        res.wb_en    = 1'b0;
        res.wb_val   = base_val;
        res.indirect = 1'b0;
        case (addr_mode_e'(mode))
            AM_MEM_IND:  res.indirect = 1'b1;
            AM_AUTO_INC: begin
                res.wb_en  = 1'b1;
                res.wb_val = base_val + elem;
            end
            AM_AUTO_DEC: begin
                res.wb_en  = 1'b1;
                res.wb_val = base_val - elem;
                res.addr   = base_val - elem;
            end
            AM_DISP:     res.addr = base_val + disp_ext;
            AM_INDEXED:  res.addr = base_val + index_val;
            AM_SCALED:   res.addr = disp_ext + base_val + idx_scaled;
            AM_PC_REL:   res.addr = pc_val + br_off;
            AM_DIRECT:   res.addr = abs_addr;
            default:     res.addr = base_val;
        endcase
    end
endmodule

// File: rtl/eag_seq.sv
module eag_seq
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  calc_res_t         calc,
    input  logic              mem_rd_valid,
    input  logic [EAG_AW-1:0] mem_rd_data,
    output logic              mem_rd_en,
    output logic [EAG_AW-1:0] mem_rd_addr,
    output logic              done,
    output logic [EAG_AW-1:0] ea,
    output logic              wb_en,
    output logic [EAG_AW-1:0] wb_val,
    output logic              busy
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SEQ_IDLE;
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
            done        <= 1'b0;
            ea          <= '0;
            wb_en       <= 1'b0;
            wb_val      <= '0;
        end else begin
            done      <= 1'b0;
            wb_en     <= 1'b0;
            mem_rd_en <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        if (calc.indirect) begin
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= calc.addr;
                            state       <= SEQ_WAIT;
                        end else begin
                            done   <= 1'b1;
                            ea     <= calc.addr;
                            wb_en  <= calc.wb_en;
                            wb_val <= calc.wb_val;
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (mem_rd_valid) begin
                        done  <= 1'b1;
                        ea    <= mem_rd_data;
                        state <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy = (state == SEQ_WAIT);
endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [EAG_MW-1:0] mode,
    input  logic [EAG_AW-1:0] base_val,
    input  logic [EAG_AW-1:0] index_val,
    input  logic [EAG_DW-1:0] disp,
    input  logic [EAG_SW-1:0] scale_sel,
    input  logic [EAG_AW-1:0] pc_val,
    input  logic [EAG_AW-1:0] br_off,
    input  logic [EAG_AW-1:0] abs_addr,
    output logic              mem_rd_en,
    output logic [EAG_AW-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [EAG_AW-1:0] mem_rd_data,
    output logic              done,
    output logic [EAG_AW-1:0] ea,
    output logic              wb_en,
    output logic [EAG_AW-1:0] wb_val
);
    calc_res_t calc;
    logic      busy;

    eag_addr_calc u_calc (
        .mode     (mode),
        .base_val (base_val),
        .index_val(index_val),
        .disp     (disp),
        .scale_sel(scale_sel),
        .pc_val   (pc_val),
        .br_off   (br_off),
        .abs_addr (abs_addr),
        .res      (calc)
    );

    eag_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .calc        (calc),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_data (mem_rd_data),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .done        (done),
        .ea          (ea),
        .wb_en       (wb_en),
        .wb_val      (wb_val),
        .busy        (busy)
    );
endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [EAG_MW-1:0] mode,
    input logic [EAG_AW-1:0] base_val,
    input logic [EAG_SW-1:0] scale_sel,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [EAG_AW-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic [EAG_AW-1:0] mem_rd_data,
    input logic              done,
    input logic [EAG_AW-1:0] ea,
    input logic              wb_en,
    input logic [EAG_AW-1:0] wb_val
);
    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && mode != EAG_MW'(AM_MEM_IND)) |=> done);

    assert_wb_needs_done_R10: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    assert_autoinc_step_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && mode == EAG_MW'(AM_AUTO_INC)) |=>
        (wb_en && ea == $past(base_val) &&
         wb_val == $past(base_val) + (EAG_AW'(1) << $past(scale_sel))));

    assert_ptr_read_issue_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && mode == EAG_MW'(AM_MEM_IND)) |=>
        (mem_rd_en && !done && mem_rd_addr == $past(base_val)));

    assert_hold_while_waiting_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rd_valid) |=> !done);

    assert_ptr_becomes_ea_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_rd_valid) |=> (done && !wb_en && ea == $past(mem_rd_data)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> (!done && !mem_rd_en));
endmodule

bind eag_top eag_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .mode        (mode),
    .base_val    (base_val),
    .scale_sel   (scale_sel),
    .busy        (busy),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_data (mem_rd_data),
    .done        (done),
    .ea          (ea),
    .wb_en       (wb_en),
    .wb_val      (wb_val)
);

// File: tb/test_eag_top.sv
module test_eag_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] base_val = '0, index_val = '0, pc_val = '0, br_off = '0, abs_addr = '0;
    logic [15:0] disp = '0;
    logic [1:0]  scale_sel = '0;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_en, done, wb_en;
    logic [31:0] mem_rd_addr, ea, wb_val;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    eag_top i_eag_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .base_val(base_val), .index_val(index_val), .disp(disp),
        .scale_sel(scale_sel), .pc_val(pc_val), .br_off(br_off),
        .abs_addr(abs_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .ea(ea), .wb_en(wb_en), .wb_val(wb_val)
    );

    task automatic check(string req, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Reference model: integer arithmetic reduced modulo 2^32
    function automatic longint wrap(longint v);
        return v & 64'hFFFF_FFFF;
    endfunction

    function automatic longint model_ea(int m, longint b, longint ix, int d,
                                        int sc, longint pc, longint bo, longint ab);
        longint elem = 1;
        for (int k = 0; k < sc; k++) elem = elem * 2;
        case (m)
            3: return wrap(b - elem);
            4: return wrap(b + d);
            5: return wrap(b + ix);
            6: return wrap(d + b + ix * elem);
            7: return wrap(pc + bo);
            8: return ab;
            default: return b;
        endcase
    endfunction

    function automatic longint model_wb(int m, longint b, int sc);
        longint elem = 1;
        for (int k = 0; k < sc; k++) elem = elem * 2;
        if (m == 2) return wrap(b + elem);
        return wrap(b - elem);
    endfunction

    task automatic one_cycle(string req, int m, longint b, longint ix, int d,
                             int sc, longint pc, longint bo, longint ab);
        longint exp_ea = model_ea(m, b, ix, d, sc, pc, bo, ab);
        bit     exp_wb = (m == 2 || m == 3);
        req_valid = 1'b1; mode = 4'(m); base_val = 32'(b); index_val = 32'(ix);
        disp = 16'(d); scale_sel = 2'(sc); pc_val = 32'(pc); br_off = 32'(bo);
        abs_addr = 32'(ab);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " done"}, done, 1);
        check({req, " ea"}, ea, exp_ea);
        check({req, " R10 wb_en"}, wb_en, exp_wb);
        if (exp_wb) check({req, " wb_val"}, wb_val, model_wb(m, b, sc));
        check({req, " no rd"}, mem_rd_en, 0);
    endtask

    task automatic indirect(longint b, longint ptr, int waits, bit stray_req);
        req_valid = 1'b1; mode = 4'd1; base_val = 32'(b);
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 rd_en", mem_rd_en, 1);
        check("R11 rd_addr", mem_rd_addr, b);
        check("R11 done low", done, 0);
        for (int w = 0; w < waits; w++) begin
            if (stray_req && w == 0) begin
                req_valid = 1'b1; mode = 4'd4; base_val = 32'h55; disp = 16'h10;
            end
            @(negedge clk);
            req_valid = 1'b0;
            check("R11 wait done", done, 0);
            check("R11 rd pulse", mem_rd_en, 0);
            if (stray_req && w == 0) check("R12 req ignored", done, 0);
        end
        mem_rd_valid = 1'b1; mem_rd_data = 32'(ptr);
        @(negedge clk);
        mem_rd_valid = 1'b0; mem_rd_data = 32'hDEAD_BEEF;
        check("R11 done", done, 1);
        check("R11 ea=ptr", ea, ptr);
        check("R11 no wb", wb_en, 0);
        @(negedge clk);
        check("R11 done one cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done", done, 0);
        check("R1 wb_en", wb_en, 0);
        check("R1 rd_en", mem_rd_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", done, 0);

        one_cycle("R2 reg-ind", 0, 32'h1000, 7, 5, 1, 0, 0, 0);
        one_cycle("R2 code12", 12, 32'hABCD_0000, 1, 1, 1, 1, 1, 1);
        one_cycle("R3 direct", 8, 32'h1111, 0, 0, 0, 0, 0, 32'h8000_0004);
        one_cycle("R4 disp pos", 4, 32'h2000, 0, 16'h0100, 0, 0, 0, 0);
        one_cycle("R4 disp neg", 4, 32'h2000, 0, -8, 0, 0, 0, 0);
        one_cycle("R5 indexed", 5, 32'hFFFF_FFF0, 32'h20, 0, 0, 0, 0, 0);
        one_cycle("R6 scaled 412", 6, 400, 3, 0, 2, 0, 0, 0);
        one_cycle("R6 scaled 508", 6, 400, 2, 100, 2, 0, 0, 0);
        one_cycle("R6 scale x1", 6, 10, 5, 0, 0, 0, 0, 0);
        one_cycle("R6 scale x2", 6, 10, 5, 0, 1, 0, 0, 0);
        one_cycle("R6 scale x8", 6, 1000, 5, -24, 3, 0, 0, 0);
        one_cycle("R7 pc fwd", 7, 0, 0, 0, 0, 32'h400, 32'h40, 0);
        one_cycle("R7 pc back", 7, 0, 0, 0, 0, 32'h400, -16, 0);
        one_cycle("R8 autoinc x1", 2, 32'h300, 0, 0, 0, 0, 0, 0);
        one_cycle("R8 autoinc x8", 2, 32'hFFFF_FFFC, 0, 0, 3, 0, 0, 0);
        one_cycle("R9 autodec x4", 3, 32'h100, 0, 0, 2, 0, 0, 0);
        one_cycle("R9 autodec wrap", 3, 0, 0, 0, 2, 0, 0, 0);
        @(negedge clk);
        check("R10 done one cycle", done, 0);

        indirect(32'h40, 32'h1234_5678, 3, 0);
        indirect(32'h80, 32'h0000_0A00, 0, 0);
        indirect(32'hC0, 32'h7777_0000, 2, 1);

        mem_rd_valid = 1'b1; mem_rd_data = 32'h9999;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        check("R12 stray valid done", done, 0);
        @(negedge clk);
        check("R12 stray valid later", done, 0);
        one_cycle("R12 recovers", 5, 1, 2, 0, 0, 0, 0, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule